// File: doc/BRIEF.md
# Memory Access Checker and Dispatcher

This block sits between a processor's fetch/load/store unit and two back ends: a physical memory port and a memory-mapped device port. Each request carries an address, a byte count (1, 2, 4 or 8, given as a log2 size), an access kind (fetch, load or store) and three ordering flags: acquire, release and reserved/conditional. The block decides whether the access is legal, and then either raises an exception or routes the access to the device port or to memory.

Legality is decided in a fixed order. Only ordered accesses have their address alignment checked: loads with acquire or reserved set, and stores with release or conditional set. After that, flag pairings the block does not support are reported on a separate error flag. Surviving accesses are routed by region. Device ranges are parameters, each marked readable and/or writable, and the memory range is a parameter too. An access is inside a range only if both its first and its last byte are inside. Instruction fetches never go to the device port.

Requests use a valid/ready handshake, with one request in flight at a time. The result, whether it comes from a back end or is decided locally, comes back as a one-cycle pulse on a single response channel.

Top module: `memacc_dispatch`

## Requirements
- R1: `req_ready` is high only when nothing is in flight. After a request is accepted, `req_ready` stays low until the response has been presented. `rsp_valid` is a pulse of exactly one cycle. At most one back-end request valid is high at a time.
- R2: A load (`req_kind`=1) with acquire or reserved set, whose address is not a multiple of its byte count, completes with `rsp_exc`=1 and `rsp_cause`=4. No back-end request is made.
- R3: A load with neither acquire nor reserved set skips the alignment check, so a misaligned plain load is still routed and returns its data.
- R4: A store (`req_kind`=2) with release or conditional set, at a misaligned address, completes with `rsp_cause`=6. A plain store skips the check and is routed.
- R5: The alignment fault wins over an unsupported flag pairing and over region routing.
- R6: A load with release set and acquire clear completes with `rsp_unsup`=1 and `rsp_exc`=0, whatever the reserved flag. A load with both acquire and release set is carried out. A request with `req_kind`=3 also reports `rsp_unsup`=1.
- R7: A store with acquire set and release clear reports `rsp_unsup`=1, whatever the conditional flag. A store with both acquire and release set is carried out.
- R8: A load that lies wholly in a readable device range goes to the device port and returns `mmio_rsp_rdata`. Otherwise a load inside memory goes to the memory port. Any other load faults with cause 5, and so does a load that memory answers with `mem_rsp_ok`=0.
- R9: A fetch (`req_kind`=0) never goes to the device port. It ignores the ordering flags and alignment. It goes to memory when inside the memory range; otherwise, or when memory answers with `mem_rsp_ok`=0, it faults with cause 1.
- R10: A store that lies in a writable device range goes to the device port; otherwise a store inside memory goes to memory; any other store faults with cause 7. A store response has `rsp_exc`=0, and its `rsp_rdata` is 1 for a device store or `mem_rsp_ok` (in bit 0) for a memory store.
- R11: A range contains an access only when the access's first byte and its last byte (address plus byte count minus one) both lie in the range's inclusive bounds. An access that straddles the end of a range is outside it.
- R12: A locally decided response (fault or unsupported) is presented in the cycle after acceptance, and no back-end request is raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of byte count |
| req_acq | input | 1 | Acquire ordering flag |
| req_rel | input | 1 | Release ordering flag |
| req_rsv | input | 1 | Reserved-load / conditional-store flag |
| req_wdata | input | DATA_W | Store data |
| bk_kind | output | 2 | Kind of the in-flight access |
| bk_addr | output | ADDR_W | Address of the in-flight access |
| bk_size | output | 2 | Size of the in-flight access |
| bk_attr | output | 3 | {reserved, release, acquire} of the in-flight access |
| bk_wdata | output | DATA_W | Store data of the in-flight access |
| mem_req_valid | output | 1 | Memory port request valid |
| mem_req_ready | input | 1 | Memory port accepts |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ok | input | 1 | Memory accepted the access |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| mmio_req_valid | output | 1 | Device port request valid |
| mmio_req_ready | input | 1 | Device port accepts |
| mmio_rsp_valid | input | 1 | Device response valid |
| mmio_rsp_rdata | input | DATA_W | Device read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data or store result |
| rsp_exc | output | 1 | Exception raised |
| rsp_cause | output | 4 | Exception cause code |
| rsp_unsup | output | 1 | Unsupported flag pairing or kind |

## Verification
A corrupted decision register shows up at the ports within the same transaction. The wrong back end asserts its request valid one cycle after acceptance. A local fault that should have been routed (or the reverse) changes the response latency from one cycle to several, and it changes the back-end hit counts. A corrupted cause or data capture is visible on the single response pulse, so each directed access compares the cause, the error flag, the data, the port that was hit and the address presented to it. A state machine stuck outside idle shows immediately as `req_ready` staying low, or as a response that never arrives.

// File: rtl/memacc_pkg.sv
package memacc_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      TGT_LOCAL = 2'd0,
      TGT_MEM   = 2'd1,
      TGT_MMIO  = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } st_e;

   localparam logic [3:0] CAUSE_NONE      = 4'd0;
   localparam logic [3:0] CAUSE_FETCH_ACC = 4'd1;
   localparam logic [3:0] CAUSE_LOAD_MIS  = 4'd4;
   localparam logic [3:0] CAUSE_LOAD_ACC  = 4'd5;
   localparam logic [3:0] CAUSE_STORE_MIS = 4'd6;
   localparam logic [3:0] CAUSE_STORE_ACC = 4'd7;

endpackage

// File: rtl/memacc_align_chk.sv
module memacc_align_chk #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              misaligned
);
   // widest offset mask needed for the largest encodable size
   localparam int LOWB = (1 << SIZE_W) - 1;

   logic [LOWB-1:0] off_mask;

   initial begin
      assert (ADDR_W >= LOWB) else $error("address narrower than offset mask");
   end

   always_comb begin
      off_mask   = LOWB'((32'd1 << size) - 32'd1);
      misaligned = |(addr[LOWB-1:0] & off_mask);
   end
endmodule

// File: rtl/memacc_order_dec.sv
module memacc_order_dec
   import memacc_pkg::*;
#(
   parameter int SIZE_W = 2,
   parameter int MAX_LG = 3
) (
   input  acc_kind_e         kind,
   input  logic              acq,
   input  logic              rel,
   input  logic              rsv,
   input  logic [SIZE_W-1:0] size,
   output logic              need_align,
   output logic              unsup
);
   logic too_wide;

   assign too_wide = (32'(size) > MAX_LG);

   always_comb begin
      need_align = 1'b0;
      unsup      = 1'b0;
      unique case (kind)
         ACC_FETCH: begin
            // ordering flags carry no meaning for fetches
            unsup = too_wide;
         end
         ACC_LOAD: begin
            need_align = acq | rsv;
            unsup      = (rel & ~acq) | too_wide;
         end
         ACC_STORE: begin
            need_align = rel | rsv;
            unsup      = (acq & ~rel) | too_wide;
         end
         default: begin
            unsup = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/memacc_region_dec.sv
module memacc_region_dec #(
   parameter int                         ADDR_W    = 32,
   parameter int                         SIZE_W    = 2,
   parameter logic [ADDR_W-1:0]          MEM_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0]          MEM_LAST  = 32'h8000_FFFF,
   parameter int                         NUM_MMIO  = 2,
   parameter logic [NUM_MMIO*ADDR_W-1:0] MMIO_BASE = {32'h2000_0000, 32'h1000_0000},
   parameter logic [NUM_MMIO*ADDR_W-1:0] MMIO_LAST = {32'h2000_00FF, 32'h1000_0FFF},
   parameter logic [NUM_MMIO-1:0]        MMIO_RD   = 2'b01,
   parameter logic [NUM_MMIO-1:0]        MMIO_WR   = 2'b11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              in_mem,
   output logic              in_mmio_rd,
   output logic              in_mmio_wr
);
   // one extra bit so that the last byte cannot wrap past the top
   localparam int EW = ADDR_W + 1;

   logic [EW-1:0]       first_b;
   logic [EW-1:0]       last_b;
   logic [NUM_MMIO-1:0] hit_rd;
   logic [NUM_MMIO-1:0] hit_wr;

   assign first_b = {1'b0, addr};
   assign last_b  = first_b + EW'((32'd1 << size) - 32'd1);

   function automatic logic covers(input logic [EW-1:0]     lo_b,
                                   input logic [EW-1:0]     hi_b,
                                   input logic [ADDR_W-1:0] base,
                                   input logic [ADDR_W-1:0] last);
      return (lo_b >= {1'b0, base}) && (hi_b <= {1'b0, last});
   endfunction

   assign in_mem = covers(first_b, last_b, MEM_BASE, MEM_LAST);

   for (genvar g = 0; g < NUM_MMIO; g++) begin : g_mmio
      logic hit;
      assign hit       = covers(first_b, last_b,
                                MMIO_BASE[g*ADDR_W +: ADDR_W],
                                MMIO_LAST[g*ADDR_W +: ADDR_W]);
      assign hit_rd[g] = hit & MMIO_RD[g];
      assign hit_wr[g] = hit & MMIO_WR[g];
   end

   assign in_mmio_rd = |hit_rd;
   assign in_mmio_wr = |hit_wr;
endmodule

// File: rtl/memacc_dispatch.sv
module memacc_dispatch
   import memacc_pkg::*;
#(
   parameter int                         ADDR_W    = 32,
   parameter int                         DATA_W    = 64,
   parameter logic [ADDR_W-1:0]          MEM_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0]          MEM_LAST  = 32'h8000_FFFF,
   parameter int                         NUM_MMIO  = 2,
   parameter logic [NUM_MMIO*ADDR_W-1:0] MMIO_BASE = {32'h2000_0000, 32'h1000_0000},
   parameter logic [NUM_MMIO*ADDR_W-1:0] MMIO_LAST = {32'h2000_00FF, 32'h1000_0FFF},
   parameter logic [NUM_MMIO-1:0]        MMIO_RD   = 2'b01,
   parameter logic [NUM_MMIO-1:0]        MMIO_WR   = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_acq,
   input  logic              req_rel,
   input  logic              req_rsv,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [1:0]        bk_kind,
   output logic [ADDR_W-1:0] bk_addr,
   output logic [1:0]        bk_size,
   output logic [2:0]        bk_attr,
   output logic [DATA_W-1:0] bk_wdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_ok,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              mmio_req_valid,
   input  logic              mmio_req_ready,
   input  logic              mmio_rsp_valid,
   input  logic [DATA_W-1:0] mmio_rsp_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_exc,
   output logic [3:0]        rsp_cause,
   output logic              rsp_unsup
);
   localparam int SIZE_W = 2;
   localparam int MAX_LG = $clog2(DATA_W / 8);

   initial begin
      assert (DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)
         else $error("DATA_W must be 8, 16, 32 or 64");
      assert (NUM_MMIO >= 1) else $error("at least one device range required");
      assert (ADDR_W >= 8) else $error("ADDR_W too small");
      assert (MEM_LAST >= MEM_BASE) else $error("memory range inverted");
   end

   // ---------------- decode of the incoming request ----------------
   acc_kind_e kind_in;
   logic      misal;
   logic      need_align;
   logic      unsup;
   logic      in_mem;
   logic      in_rd;
   logic      in_wr;

   assign kind_in = acc_kind_e'(req_kind);

   memacc_align_chk #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W)
   ) u_align (
      .addr       (req_addr),
      .size       (req_size),
      .misaligned (misal)
   );

   memacc_order_dec #(
      .SIZE_W (SIZE_W),
      .MAX_LG (MAX_LG)
   ) u_order (
      .kind       (kind_in),
      .acq        (req_acq),
      .rel        (req_rel),
      .rsv        (req_rsv),
      .size       (req_size),
      .need_align (need_align),
      .unsup      (unsup)
   );

   memacc_region_dec #(
      .ADDR_W    (ADDR_W),
      .SIZE_W    (SIZE_W),
      .MEM_BASE  (MEM_BASE),
      .MEM_LAST  (MEM_LAST),
      .NUM_MMIO  (NUM_MMIO),
      .MMIO_BASE (MMIO_BASE),
      .MMIO_LAST (MMIO_LAST),
      .MMIO_RD   (MMIO_RD),
      .MMIO_WR   (MMIO_WR)
   ) u_region (
      .addr       (req_addr),
      .size       (req_size),
      .in_mem     (in_mem),
      .in_mmio_rd (in_rd),
      .in_mmio_wr (in_wr)
   );

   tgt_e       d_tgt;
   logic       d_exc;
   logic [3:0] d_cause;
   logic       d_unsup;

   // priority: alignment, then flag pairing, then region routing
   always_comb begin
      d_tgt   = TGT_LOCAL;
      d_exc   = 1'b0;
      d_cause = CAUSE_NONE;
      d_unsup = 1'b0;
      if (need_align && misal) begin
         d_exc   = 1'b1;
         d_cause = (kind_in == ACC_STORE) ? CAUSE_STORE_MIS : CAUSE_LOAD_MIS;
      end else if (unsup) begin
         d_unsup = 1'b1;
      end else begin
         unique case (kind_in)
            ACC_FETCH: begin
               if (in_mem) d_tgt = TGT_MEM;
               else begin
                  d_exc   = 1'b1;
                  d_cause = CAUSE_FETCH_ACC;
               end
            end
            ACC_LOAD: begin
               if (in_rd)       d_tgt = TGT_MMIO;
               else if (in_mem) d_tgt = TGT_MEM;
               else begin
                  d_exc   = 1'b1;
                  d_cause = CAUSE_LOAD_ACC;
               end
            end
            ACC_STORE: begin
               if (in_wr)       d_tgt = TGT_MMIO;
               else if (in_mem) d_tgt = TGT_MEM;
               else begin
                  d_exc   = 1'b1;
                  d_cause = CAUSE_STORE_ACC;
               end
            end
            default: begin
               d_unsup = 1'b1;
            end
         endcase
      end
   end

   // ---------------- transaction state ----------------
   st_e               st;
   tgt_e              r_tgt;
   acc_kind_e         r_kind;
   logic [ADDR_W-1:0] r_addr;
   logic [1:0]        r_size;
   logic [2:0]        r_attr;
   logic [DATA_W-1:0] r_wdata;
   logic [DATA_W-1:0] r_rdata;
   logic              r_exc;
   logic [3:0]        r_cause;
   logic              r_unsup;
   logic              bk_accept;

   assign bk_accept = ((r_tgt == TGT_MEM)  && mem_req_ready) ||
                      ((r_tgt == TGT_MMIO) && mmio_req_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         r_tgt   <= TGT_LOCAL;
         r_kind  <= ACC_FETCH;
         r_addr  <= '0;
         r_size  <= '0;
         r_attr  <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
         r_exc   <= 1'b0;
         r_cause <= CAUSE_NONE;
         r_unsup <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  r_tgt   <= d_tgt;
                  r_kind  <= kind_in;
                  r_addr  <= req_addr;
                  r_size  <= req_size;
                  r_attr  <= {req_rsv, req_rel, req_acq};
                  r_wdata <= req_wdata;
                  r_rdata <= '0;
                  r_exc   <= d_exc;
                  r_cause <= d_cause;
                  r_unsup <= d_unsup;
                  st      <= (d_tgt == TGT_LOCAL) ? ST_RESP : ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (bk_accept) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (r_tgt == TGT_MEM && mem_rsp_valid) begin
                  st <= ST_RESP;
                  if (r_kind == ACC_STORE) begin
                     r_rdata <= DATA_W'(mem_rsp_ok);
                  end else if (mem_rsp_ok) begin
                     r_rdata <= mem_rsp_rdata;
                  end else begin
                     r_exc   <= 1'b1;
                     r_cause <= (r_kind == ACC_FETCH) ? CAUSE_FETCH_ACC : CAUSE_LOAD_ACC;
                  end
               end else if (r_tgt == TGT_MMIO && mmio_rsp_valid) begin
                  st      <= ST_RESP;
                  r_rdata <= (r_kind == ACC_STORE) ? DATA_W'(1) : mmio_rsp_rdata;
               end
            end
            default: begin
               st <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready      = (st == ST_IDLE);
   assign mem_req_valid  = (st == ST_ISSUE) && (r_tgt == TGT_MEM);
   assign mmio_req_valid = (st == ST_ISSUE) && (r_tgt == TGT_MMIO);
   assign bk_kind        = r_kind;
   assign bk_addr        = r_addr;
   assign bk_size        = r_size;
   assign bk_attr        = r_attr;
   assign bk_wdata       = r_wdata;
   assign rsp_valid      = (st == ST_RESP);
   assign rsp_rdata      = r_rdata;
   assign rsp_exc        = r_exc;
   assign rsp_cause      = r_cause;
   assign rsp_unsup      = r_unsup;
endmodule

// File: rtl/memacc_dispatch_chk.sv
module memacc_dispatch_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        bk_kind,
   input logic [ADDR_W-1:0] bk_addr,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mmio_req_valid,
   input logic              rsp_valid,
   input logic              rsp_exc,
   input logic [3:0]        rsp_cause,
   input logic              rsp_unsup
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !mmio_req_valid && !rsp_valid));

   // R1
   accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R1
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R1
   single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req_valid, mmio_req_valid}));

   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(bk_addr)));

   // R9
   fetch_not_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mmio_req_valid |-> (bk_kind != 2'd0));

   // R6
   err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_exc && rsp_unsup));

   // R2
   cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc) |-> (rsp_cause inside {4'd1, 4'd4, 4'd5, 4'd6, 4'd7}));
endmodule

bind memacc_dispatch memacc_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/memacc_dispatch_test.sv
module memacc_dispatch_test;
   localparam int AW = 32;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          req_acq = 1'b0;
   logic          req_rel = 1'b0;
   logic          req_rsv = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    bk_kind;
   logic [AW-1:0] bk_addr;
   logic [1:0]    bk_size;
   logic [2:0]    bk_attr;
   logic [DW-1:0] bk_wdata;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic          mem_rsp_valid = 1'b0;
   logic          mem_rsp_ok = 1'b0;
   logic [DW-1:0] mem_rsp_rdata = '0;
   logic          mmio_req_valid;
   logic          mmio_req_ready = 1'b1;
   logic          mmio_rsp_valid = 1'b0;
   logic [DW-1:0] mmio_rsp_rdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_exc;
   logic [3:0]    rsp_cause;
   logic          rsp_unsup;

   always #2.5 clk = ~clk;

   memacc_dispatch uut (.*);

   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;
   int            mem_hits = 0;
   int            mmio_hits = 0;
   logic [AW-1:0] seen_addr = '0;
   logic          mem_ok_knob = 1'b1;
   logic [DW-1:0] mem_data_knob = 64'h1111_2222_3333_4444;
   logic [DW-1:0] mmio_data_knob = 64'hDEAD_BEEF_0000_00A5;

   int            got_lat;
   logic          got_exc;
   logic [3:0]    got_cause;
   logic          got_unsup;
   logic [DW-1:0] got_data;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory back end: answers two cycles after taking a request
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            mem_hits++;
            seen_addr = bk_addr;
            @(negedge clk);
            @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_ok    = mem_ok_knob;
            mem_rsp_rdata = mem_data_knob;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // device back end: same timing
   initial begin
      forever begin
         @(negedge clk);
         if (mmio_req_valid) begin
            mmio_hits++;
            seen_addr = bk_addr;
            @(negedge clk);
            @(negedge clk);
            mmio_rsp_valid = 1'b1;
            mmio_rsp_rdata = mmio_data_knob;
            @(negedge clk);
            mmio_rsp_valid = 1'b0;
         end
      end
   end

   task automatic do_req(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] s,
                         input logic aq, input logic rl, input logic rv);
      @(negedge clk);
      mem_hits  = 0;
      mmio_hits = 0;
      seen_addr = '0;
      chk("R1 ready before request", 64'(req_ready), 64'd1);
      req_kind  = k;
      req_addr  = a;
      req_size  = s;
      req_acq   = aq;
      req_rel   = rl;
      req_rsv   = rv;
      req_wdata = 64'h0BAD_F00D_CAFE_0001;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got_lat = 1;
      while (!rsp_valid && got_lat < 50) begin
         chk("R1 ready low while busy", 64'(req_ready), 64'd0);
         @(negedge clk);
         got_lat++;
      end
      chk("R1 response arrives", 64'(rsp_valid), 64'd1);
      got_exc   = rsp_exc;
      got_cause = rsp_cause;
      got_unsup = rsp_unsup;
      got_data  = rsp_rdata;
      @(negedge clk);
      chk("R1 response is one pulse", 64'(rsp_valid), 64'd0);
   endtask

   task automatic expect_local(input string tag, input logic exc, input logic [3:0] cause,
                               input logic unsup);
      chk({tag, " exc"}, 64'(got_exc), 64'(exc));
      chk({tag, " cause"}, 64'(got_cause), 64'(cause));
      chk({tag, " unsup"}, 64'(got_unsup), 64'(unsup));
      chk({tag, " R12 latency"}, 64'(got_lat), 64'd1);
      chk({tag, " R12 no memory request"}, 64'(mem_hits), 64'd0);
      chk({tag, " R12 no device request"}, 64'(mmio_hits), 64'd0);
   endtask

   task automatic expect_mem(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk({tag, " memory hit"}, 64'(mem_hits), 64'd1);
      chk({tag, " device hit"}, 64'(mmio_hits), 64'd0);
      chk({tag, " address"}, 64'(seen_addr), 64'(a));
      chk({tag, " exc"}, 64'(got_exc), 64'd0);
      chk({tag, " unsup"}, 64'(got_unsup), 64'd0);
      chk({tag, " data"}, got_data, d);
   endtask

   task automatic expect_mmio(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk({tag, " device hit"}, 64'(mmio_hits), 64'd1);
      chk({tag, " memory hit"}, 64'(mem_hits), 64'd0);
      chk({tag, " address"}, 64'(seen_addr), 64'(a));
      chk({tag, " exc"}, 64'(got_exc), 64'd0);
      chk({tag, " data"}, got_data, d);
   endtask

   task automatic t_reset();
      chk("R1 reset ready", 64'(req_ready), 64'd1);
      chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1 reset mem valid", 64'(mem_req_valid), 64'd0);
      chk("R1 reset device valid", 64'(mmio_req_valid), 64'd0);
   endtask

   task automatic t_load_align();
      do_req(2'd1, 32'h8000_0002, 2'd2, 1'b1, 1'b0, 1'b0);
      expect_local("R2 acquire load misaligned", 1'b1, 4'd4, 1'b0);
      do_req(2'd1, 32'h8000_0004, 2'd3, 1'b0, 1'b0, 1'b1);
      expect_local("R2 reserved load misaligned", 1'b1, 4'd4, 1'b0);
      do_req(2'd1, 32'h8000_0008, 2'd3, 1'b1, 1'b0, 1'b1);
      expect_mem("R2 aligned reserved-acquire load", 32'h8000_0008, mem_data_knob);
      do_req(2'd1, 32'h8000_0003, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_mem("R3 plain misaligned load", 32'h8000_0003, mem_data_knob);
   endtask

   task automatic t_store_align();
      do_req(2'd2, 32'h8000_0001, 2'd1, 1'b0, 1'b1, 1'b0);
      expect_local("R4 release store misaligned", 1'b1, 4'd6, 1'b0);
      do_req(2'd2, 32'h8000_0006, 2'd2, 1'b0, 1'b0, 1'b1);
      expect_local("R4 conditional store misaligned", 1'b1, 4'd6, 1'b0);
      do_req(2'd2, 32'h8000_0005, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_mem("R4 plain misaligned store", 32'h8000_0005, 64'd1);
   endtask

   task automatic t_priority();
      do_req(2'd1, 32'h8000_0002, 2'd2, 1'b0, 1'b1, 1'b1);
      expect_local("R5 misaligned beats unsupported load", 1'b1, 4'd4, 1'b0);
      do_req(2'd2, 32'h8000_0002, 2'd2, 1'b1, 1'b0, 1'b1);
      expect_local("R5 misaligned beats unsupported store", 1'b1, 4'd6, 1'b0);
      do_req(2'd1, 32'h4000_0001, 2'd1, 1'b1, 1'b0, 1'b0);
      expect_local("R5 misaligned beats region fault", 1'b1, 4'd4, 1'b0);
   endtask

   task automatic t_load_flags();
      do_req(2'd1, 32'h8000_0010, 2'd2, 1'b0, 1'b1, 1'b0);
      expect_local("R6 release-only load", 1'b0, 4'd0, 1'b1);
      do_req(2'd1, 32'h8000_0010, 2'd2, 1'b0, 1'b1, 1'b1);
      expect_local("R6 release reserved load", 1'b0, 4'd0, 1'b1);
      do_req(2'd1, 32'h8000_0010, 2'd2, 1'b1, 1'b1, 1'b0);
      expect_mem("R6 strong acquire load", 32'h8000_0010, mem_data_knob);
      do_req(2'd3, 32'h8000_0010, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_local("R6 reserved kind", 1'b0, 4'd0, 1'b1);
   endtask

   task automatic t_store_flags();
      do_req(2'd2, 32'h8000_0020, 2'd3, 1'b1, 1'b0, 1'b0);
      expect_local("R7 acquire-only store", 1'b0, 4'd0, 1'b1);
      do_req(2'd2, 32'h8000_0020, 2'd3, 1'b1, 1'b0, 1'b1);
      expect_local("R7 acquire conditional store", 1'b0, 4'd0, 1'b1);
      do_req(2'd2, 32'h8000_0020, 2'd3, 1'b1, 1'b1, 1'b0);
      expect_mem("R7 strong release store", 32'h8000_0020, 64'd1);
   endtask

   task automatic t_load_route();
      do_req(2'd1, 32'h1000_0010, 2'd3, 1'b0, 1'b0, 1'b0);
      expect_mmio("R8 readable device load", 32'h1000_0010, mmio_data_knob);
      do_req(2'd1, 32'h2000_0000, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_local("R8 write-only range load", 1'b1, 4'd5, 1'b0);
      mem_ok_knob = 1'b0;
      do_req(2'd1, 32'h8000_0040, 2'd2, 1'b0, 1'b0, 1'b0);
      mem_ok_knob = 1'b1;
      chk("R8 rejected load memory hit", 64'(mem_hits), 64'd1);
      chk("R8 rejected load exc", 64'(got_exc), 64'd1);
      chk("R8 rejected load cause", 64'(got_cause), 64'd5);
   endtask

   task automatic t_fetch();
      do_req(2'd0, 32'h1000_0010, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_local("R9 fetch from device range", 1'b1, 4'd1, 1'b0);
      do_req(2'd0, 32'h8000_0102, 2'd2, 1'b1, 1'b1, 1'b1);
      expect_mem("R9 fetch ignores flags and alignment", 32'h8000_0102, mem_data_knob);
      mem_ok_knob = 1'b0;
      do_req(2'd0, 32'h8000_0100, 2'd2, 1'b0, 1'b0, 1'b0);
      mem_ok_knob = 1'b1;
      chk("R9 rejected fetch exc", 64'(got_exc), 64'd1);
      chk("R9 rejected fetch cause", 64'(got_cause), 64'd1);
   endtask

   task automatic t_store_route();
      do_req(2'd2, 32'h2000_0004, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_mmio("R10 writable device store", 32'h2000_0004, 64'd1);
      do_req(2'd2, 32'h1000_0008, 2'd3, 1'b0, 1'b1, 1'b0);
      expect_mmio("R10 read-write device store", 32'h1000_0008, 64'd1);
      mem_ok_knob = 1'b0;
      do_req(2'd2, 32'h8000_0080, 2'd3, 1'b0, 1'b0, 1'b0);
      mem_ok_knob = 1'b1;
      expect_mem("R10 memory store refused", 32'h8000_0080, 64'd0);
      do_req(2'd2, 32'h9000_0000, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_local("R10 store outside all ranges", 1'b1, 4'd7, 1'b0);
   endtask

   task automatic t_bounds();
      do_req(2'd1, 32'h8000_FFF8, 2'd3, 1'b0, 1'b0, 1'b0);
      expect_mem("R11 last memory dword", 32'h8000_FFF8, mem_data_knob);
      do_req(2'd1, 32'h8000_FFFC, 2'd3, 1'b0, 1'b0, 1'b0);
      expect_local("R11 load straddling memory end", 1'b1, 4'd5, 1'b0);
      do_req(2'd1, 32'h1000_0FFC, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_mmio("R11 last device word", 32'h1000_0FFC, mmio_data_knob);
      do_req(2'd1, 32'h1000_0FFC, 2'd3, 1'b0, 1'b0, 1'b0);
      expect_local("R11 load straddling device end", 1'b1, 4'd5, 1'b0);
      do_req(2'd2, 32'h2000_00FE, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_local("R11 store straddling device end", 1'b1, 4'd7, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_align();
      t_store_align();
      t_priority();
      t_load_flags();
      t_store_flags();
      t_load_route();
      t_fetch();
      t_store_route();
      t_bounds();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule